// File: doc/BRIEF.md
# Prefix-Detecting Two-Stage Instruction Decoder

This block turns a byte stream from instruction fetch into decoded instruction bundles that always carry the same field set. Two instruction lengths coexist in the stream: a plain three-byte form, and a four-byte form whose lead byte begins with a reserved six-bit escape code. That escape code announces an extra byte, so that the guarded form can name one of 32 predicate registers. The escape is consumed by the decoder and never reaches the output. Plain instructions come out with predicate index 0, the entry that always reads true.

Fetch hands over a window of one to several bytes per transfer with a valid/ready handshake. The first stage gathers the bytes in a small alignment buffer, so an instruction may straddle any number of windows. It looks at the lead byte to choose a length of three or four, waits until that many bytes are present, and steers them into a stage register with the escape removed. The second stage splits the fields and presents them to the consumer with a second valid/ready handshake. A flush input empties both stages and the buffer at once, so that decode can restart at a new fetch target.

Top module: `pfx_decoder`

## Requirements
- R1: An instruction whose lead byte has bits [7:2] not equal to 6'h3F is three bytes long. Its bytes, first to last, form a 24-bit word with opcode in [23:18], destination in [17:13], source A in [12:8] and an 8-bit source B in [7:0]. It is output with predicate index 0 and the prefixed flag at 0.
- R2: An instruction whose lead byte has bits [7:2] equal to 6'h3F is four bytes long. Its bytes, first to last, form a 32-bit word with opcode in [25:20], predicate index in [19:15], destination in [14:10], source A in [9:5] and source B in [4:0]. Source B is zero-extended to 8 bits and the prefixed flag is 1.
- R3: Input byte j of a window sits at in_bytes[8*j+7:8*j], and in_count (1 to the window size) tells how many bytes are valid. An instruction whose bytes arrive over several windows is decoded only once all of its bytes are present. No output is produced while it is incomplete.
- R4: Decoded instructions leave in stream order, each exactly once. While out_valid is high and out_ready is low, out_valid and every output field hold their values.
- R5: A cycle with flush high clears every buffered byte and both stage registers. In the next cycle out_valid is 0. Bytes offered after the flush decode as a fresh stream, unaffected by any partial instruction from before it.
- R6: in_ready is low while flush is high or while the alignment buffer holds more than (buffer size minus window size) bytes. Input is therefore refused under sustained output backpressure, with no byte lost.
- R7: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all buffered and in-flight instructions |
| in_valid | input | 1 | Fetch window valid |
| in_ready | output | 1 | Decoder accepts the window this cycle |
| in_bytes | input | 8*WIN_BYTES | Window bytes, stream byte 0 in the low byte |
| in_count | input | clog2(WIN_BYTES+1) | Number of valid bytes in the window |
| out_ready | input | 1 | Consumer accepts the bundle |
| out_valid | output | 1 | Decoded bundle valid |
| out_opcode | output | 6 | Operation code |
| out_pred | output | 5 | Predicate register index, 0 when unguarded |
| out_dst | output | 5 | Destination register index |
| out_src_a | output | 5 | First source operand |
| out_src_b | output | 8 | Second source operand, zero-extended for the four-byte form |
| out_prefixed | output | 1 | Instruction carried the escape prefix |

## Verification
The assertions assume that fetch never offers a window with in_count of zero or above the window size. They also assume that the stream starts on an instruction boundary after reset and after each flush, because the decoder cannot recover alignment from the bytes themselves. The stimulus builds the stream from whole encoded instructions, cuts it into windows of random legal length, and restarts it at a fresh instruction after each flush. Unused window bytes are filled with random junk to show that they are ignored.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;

  localparam int OPC_W = 6;
  localparam int REG_W = 5;
  localparam int SRCB_W = 8;
  localparam int PAYLOAD_W = 26;
  localparam int HEAD_BYTES = 4;
  localparam int HEAD_W = HEAD_BYTES * 8;
  localparam logic [OPC_W-1:0] ESC_CODE = 6'h3F;
  localparam logic [2:0] LEN_PLAIN = 3'd3;
  localparam logic [2:0] LEN_GUARDED = 3'd4;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [REG_W-1:0]  pred;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src_a;
    logic [SRCB_W-1:0] src_b;
    logic              prefixed;
  } dec_bundle_t;

  // Lead-byte test for the escape code.
  function automatic logic has_escape(input logic [7:0] lead);
    return lead[7:2] == ESC_CODE;
  endfunction

  // Byte length implied by the lead byte.
  function automatic logic [2:0] byte_len(input logic [7:0] lead);
    return has_escape(lead) ? LEN_GUARDED : LEN_PLAIN;
  endfunction

  // Field split of a stripped payload; plain words sit in the low 24 bits.
  function automatic dec_bundle_t split_fields(input logic guarded,
                                               input logic [PAYLOAD_W-1:0] pl);
    dec_bundle_t d;
    if (guarded) begin
      d.opc      = pl[25:20];
      d.pred     = pl[19:15];
      d.dst      = pl[14:10];
      d.src_a    = pl[9:5];
      d.src_b    = {3'b000, pl[4:0]};
      d.prefixed = 1'b1;
    end else begin
      d.opc      = pl[23:18];
      d.pred     = '0;
      d.dst      = pl[17:13];
      d.src_a    = pl[12:8];
      d.src_b    = pl[7:0];
      d.prefixed = 1'b0;
    end
    return d;
  endfunction

endpackage

// File: rtl/pfx_align_buf.sv
module pfx_align_buf #(
  parameter int BUF_BYTES = 8,
  parameter int WIN_BYTES = 4,
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int IN_W  = $clog2(WIN_BYTES + 1),
  localparam int IDX_W = $clog2(BUF_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [8*WIN_BYTES-1:0]        in_bytes,
  input  logic [IN_W-1:0]               in_count,
  input  logic                          pop,
  input  logic [2:0]                    pop_len,
  output logic [pfx_dec_pkg::HEAD_W-1:0] head,
  output logic [CNT_W-1:0]              fill
);
  import pfx_dec_pkg::*;

  localparam logic [CNT_W-1:0] ACCEPT_MAX = CNT_W'(BUF_BYTES - WIN_BYTES);

  logic [7:0]       mem   [BUF_BYTES];
  logic [7:0]       mem_n [BUF_BYTES];
  logic [CNT_W-1:0] pop_n;
  logic [CNT_W-1:0] keep;
  logic [CNT_W-1:0] fill_n;
  logic             push;

  assign in_ready = !flush && (fill <= ACCEPT_MAX);
  assign push     = in_valid && in_ready;
  assign pop_n    = pop ? CNT_W'(pop_len) : '0;
  assign keep     = fill - pop_n;
  assign fill_n   = keep + (push ? CNT_W'(in_count) : '0);

  // Shift out the popped bytes and append the accepted window behind the rest.
  always_comb begin
    for (int i = 0; i < BUF_BYTES; i++) begin
      int src;
      int wpos;
      src  = i + int'(pop_n);
      wpos = i - int'(keep);
      mem_n[i] = mem[i];
      if (i < int'(keep) && src < BUF_BYTES) begin
        mem_n[i] = mem[IDX_W'(src)];
      end else if (push && wpos >= 0 && wpos < int'(in_count) && wpos < WIN_BYTES) begin
        mem_n[i] = in_bytes[8*wpos +: 8];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < HEAD_BYTES; k++) begin
      head[HEAD_W-1-8*k -: 8] = mem[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= '0;
    end else if (flush) begin
      fill <= '0;
    end else begin
      fill <= fill_n;
      for (int i = 0; i < BUF_BYTES; i++) mem[i] <= mem_n[i];
    end
  end

endmodule

// File: rtl/pfx_steer.sv
module pfx_steer #(
  parameter int BUF_BYTES = 8,
  localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic [pfx_dec_pkg::HEAD_W-1:0]    head,
  input  logic [CNT_W-1:0]                  fill,
  output logic                              pop,
  output logic [2:0]                        pop_len,
  input  logic                              s1_take,
  output logic                              s1_valid,
  output logic                              s1_guarded,
  output logic [pfx_dec_pkg::PAYLOAD_W-1:0] s1_payload
);
  import pfx_dec_pkg::*;

  logic lead_esc;
  logic whole_inst;
  logic s1_free;

  assign lead_esc   = has_escape(head[HEAD_W-1 -: 8]);
  assign pop_len    = byte_len(head[HEAD_W-1 -: 8]);
  assign whole_inst = fill >= CNT_W'(pop_len);
  assign s1_free    = !s1_valid || s1_take;
  assign pop        = whole_inst && s1_free && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_guarded <= 1'b0;
      s1_payload <= '0;
    end else if (flush) begin
      s1_valid <= 1'b0;
    end else if (pop) begin
      s1_valid   <= 1'b1;
      s1_guarded <= lead_esc;
      s1_payload <= lead_esc ? head[PAYLOAD_W-1:0]
                             : {2'b00, head[HEAD_W-1:8]};
    end else if (s1_take) begin
      s1_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pfx_field_dec.sv
module pfx_field_dec (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              s1_valid,
  input  logic                              s1_guarded,
  input  logic [pfx_dec_pkg::PAYLOAD_W-1:0] s1_payload,
  output logic                              s1_take,
  input  logic                              out_ready,
  output logic                              out_valid,
  output pfx_dec_pkg::dec_bundle_t          out_bundle
);
  import pfx_dec_pkg::*;

  assign s1_take = s1_valid && (!out_valid || out_ready) && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_bundle <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (s1_take) begin
      out_valid  <= 1'b1;
      out_bundle <= split_fields(s1_guarded, s1_payload);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder #(
  parameter int BUF_BYTES = 8,
  parameter int WIN_BYTES = 4,
  localparam int IN_W = $clog2(WIN_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [8*WIN_BYTES-1:0] in_bytes,
  input  logic [IN_W-1:0]        in_count,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [5:0]             out_opcode,
  output logic [4:0]             out_pred,
  output logic [4:0]             out_dst,
  output logic [4:0]             out_src_a,
  output logic [7:0]             out_src_b,
  output logic                   out_prefixed
);
  import pfx_dec_pkg::*;

  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic [HEAD_W-1:0]    buf_head;
  logic [CNT_W-1:0]     buf_fill;
  logic                 buf_pop;
  logic [2:0]           buf_pop_len;
  logic                 s1_valid;
  logic                 s1_guarded;
  logic [PAYLOAD_W-1:0] s1_payload;
  logic                 s1_take;
  dec_bundle_t          dec_q;

  pfx_align_buf #(.BUF_BYTES(BUF_BYTES), .WIN_BYTES(WIN_BYTES)) u_align (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_count(in_count),
    .pop(buf_pop), .pop_len(buf_pop_len),
    .head(buf_head), .fill(buf_fill)
  );

  pfx_steer #(.BUF_BYTES(BUF_BYTES)) u_steer (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .head(buf_head), .fill(buf_fill),
    .pop(buf_pop), .pop_len(buf_pop_len),
    .s1_take(s1_take), .s1_valid(s1_valid),
    .s1_guarded(s1_guarded), .s1_payload(s1_payload)
  );

  pfx_field_dec u_fields (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .s1_valid(s1_valid), .s1_guarded(s1_guarded), .s1_payload(s1_payload),
    .s1_take(s1_take), .out_ready(out_ready),
    .out_valid(out_valid), .out_bundle(dec_q)
  );

  assign out_opcode   = dec_q.opc;
  assign out_pred     = dec_q.pred;
  assign out_dst      = dec_q.dst;
  assign out_src_a    = dec_q.src_a;
  assign out_src_b    = dec_q.src_b;
  assign out_prefixed = dec_q.prefixed;

endmodule

// File: rtl/pfx_decoder_chk.sv
module pfx_decoder_chk #(
  parameter int BUF_BYTES = 8,
  parameter int WIN_BYTES = 4,
  localparam int IN_W  = $clog2(WIN_BYTES + 1),
  localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IN_W-1:0]  in_count,
  input logic             out_ready,
  input logic             out_valid,
  input logic [5:0]       out_opcode,
  input logic [4:0]       out_pred,
  input logic [4:0]       out_dst,
  input logic [4:0]       out_src_a,
  input logic [7:0]       out_src_b,
  input logic             out_prefixed,
  input logic [CNT_W-1:0] fill,
  input logic             s1_valid
);

  // R1: unguarded bundles carry the always-true predicate
  p_plain_pred_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_prefixed |-> out_pred == 5'd0);

  // R2: the short source of a guarded form is zero-extended
  p_guarded_srcb_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prefixed |-> out_src_b[7:5] == 3'b000);

  // R3: window length legal whenever a window is taken
  p_window_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> in_count >= IN_W'(1) && in_count <= IN_W'(WIN_BYTES));

  // R4: a stalled bundle is held unchanged
  p_hold_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_opcode)
      && $stable(out_pred) && $stable(out_dst) && $stable(out_src_a)
      && $stable(out_src_b) && $stable(out_prefixed));

  // R5: flush empties every stage
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !s1_valid && fill == '0);

  // R6: the buffer never overfills
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(BUF_BYTES));

  // R6: no acceptance while flushing
  p_no_take_in_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

endmodule

bind pfx_decoder pfx_decoder_chk #(.BUF_BYTES(BUF_BYTES), .WIN_BYTES(WIN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .in_valid(in_valid), .in_ready(in_ready), .in_count(in_count),
  .out_ready(out_ready), .out_valid(out_valid),
  .out_opcode(out_opcode), .out_pred(out_pred), .out_dst(out_dst),
  .out_src_a(out_src_a), .out_src_b(out_src_b), .out_prefixed(out_prefixed),
  .fill(buf_fill), .s1_valid(s1_valid)
);

// File: tb/pfx_decoder_test.sv
`timescale 1ns/1ps
module pfx_decoder_test;
  localparam int WIN = 4;
  localparam int BUFB = 8;
  localparam int INW = $clog2(WIN + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, flush, in_valid, in_ready, out_ready, out_valid, out_prefixed;
  logic [8*WIN-1:0] in_bytes;
  logic [INW-1:0] in_count;
  logic [5:0] out_opcode;
  logic [4:0] out_pred, out_dst, out_src_a;
  logic [7:0] out_src_b;

  pfx_decoder #(.BUF_BYTES(BUFB), .WIN_BYTES(WIN)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_count(in_count),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_opcode(out_opcode), .out_pred(out_pred), .out_dst(out_dst),
    .out_src_a(out_src_a), .out_src_b(out_src_b), .out_prefixed(out_prefixed)
  );

  logic [7:0] strm [0:4095];
  int s_len = 0, s_ptr = 0, feed_lim = 0;
  logic [30:0] exp_q [0:1023];
  int e_wr = 0, e_rd = 0;
  int checks = 0, errors = 0;
  int max_win = 4, vpct = 100, rpct = 100;
  logic held = 1'b0;
  logic [30:0] held_val;
  logic done = 1'b0;

  function automatic logic [30:0] pack_out();
    return {out_opcode, out_pred, out_dst, out_src_a, out_src_b, out_prefixed};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Encode one instruction into the stream and record its expected bundle.
  task automatic add_inst(input bit g, input logic [5:0] opc, input logic [4:0] pred,
                          input logic [4:0] dst, input logic [4:0] sa,
                          input logic [7:0] sb);
    logic [31:0] w;
    if (g) begin
      w = {6'h3F, opc, pred, dst, sa, sb[4:0]};
      for (int k = 0; k < 4; k++) strm[s_len + k] = w[31-8*k -: 8];
      s_len += 4;
      exp_q[e_wr] = {opc, pred, dst, sa, 3'b000, sb[4:0], 1'b1};
    end else begin
      w = {8'h00, opc, dst, sa, sb};
      for (int k = 0; k < 3; k++) strm[s_len + k] = w[23-8*k -: 8];
      s_len += 3;
      exp_q[e_wr] = {opc, 5'd0, dst, sa, sb, 1'b0};
    end
    e_wr++;
  endtask

  task automatic add_random();
    bit g;
    logic [5:0] opc;
    g = ($urandom % 100) < 40;
    opc = g ? 6'($urandom) : 6'($urandom % 63);
    add_inst(g, opc, 5'($urandom), 5'($urandom), 5'($urandom), 8'($urandom));
  endtask

  task automatic step(input bit fl);
    int n;
    @(negedge clk);
    if (held && !fl) begin
      check(out_valid == 1'b1, "R4 hold valid", 32'(out_valid), 32'd1);
      check(pack_out() == held_val, "R4 hold fields", 32'(pack_out()), 32'(held_val));
    end
    flush = fl;
    out_ready = (($urandom % 100) < rpct);
    #1;
    in_valid = 1'b0;
    for (int j = 0; j < WIN; j++) in_bytes[8*j +: 8] = 8'($urandom);
    in_count = INW'(1);
    if (!fl && s_ptr < feed_lim && in_ready && (($urandom % 100) < vpct)) begin
      n = 1 + int'($urandom % max_win);
      if (n > feed_lim - s_ptr) n = feed_lim - s_ptr;
      for (int j = 0; j < n; j++) in_bytes[8*j +: 8] = strm[s_ptr + j];
      in_count = INW'(n);
      in_valid = 1'b1;
      s_ptr += n;
    end
    if (!fl && out_valid && out_ready) begin
      if (e_rd >= e_wr) begin
        check(1'b0, "R4 unexpected output", 32'(pack_out()), 32'd0);
      end else begin
        check(pack_out() == exp_q[e_rd], exp_q[e_rd][0] ? "R2 guarded decode" : "R1 plain decode",
              32'(pack_out()), 32'(exp_q[e_rd]));
        e_rd++;
      end
    end
    held = !fl && out_valid && !out_ready;
    held_val = pack_out();
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_bytes = '0; in_count = INW'(1);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7 reset out_valid", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R7 reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // R3: a guarded instruction delivered one byte at a time, held back at three
    add_inst(1'b1, 6'h15, 5'd9, 5'd3, 5'd17, 8'd30);
    feed_lim = s_ptr + 3; max_win = 1; vpct = 100; rpct = 100;
    repeat (8) step(1'b0);
    check(out_valid == 1'b0, "R3 incomplete no output", 32'(out_valid), 32'd0);
    check(e_rd == e_wr - 1, "R3 incomplete none taken", 32'(e_rd), 32'(e_wr - 1));
    feed_lim = s_len;
    repeat (8) step(1'b0);
    check(e_rd == e_wr, "R3 straddled emitted", 32'(e_rd), 32'(e_wr));

    // R6 and R4: full backpressure, then release
    for (int i = 0; i < 20; i++) add_random();
    feed_lim = s_len; max_win = 4; rpct = 0;
    repeat (30) step(1'b0);
    check(in_ready == 1'b0, "R6 ready low when full", 32'(in_ready), 32'd0);
    check(out_valid == 1'b1, "R4 stalled valid", 32'(out_valid), 32'd1);
    rpct = 100;
    repeat (60) step(1'b0);
    check(e_rd == e_wr, "R4 all drained in order", 32'(e_rd), 32'(e_wr));

    // R5: flush with work in flight and a partial instruction buffered
    for (int i = 0; i < 5; i++) add_random();
    add_inst(1'b1, 6'h2A, 5'd31, 5'd1, 5'd2, 8'd4);
    feed_lim = s_len - 2; rpct = 0;
    repeat (10) step(1'b0);
    step(1'b1);
    check(in_ready == 1'b0, "R6 ready low in flush", 32'(in_ready), 32'd0);
    e_rd = e_wr; s_ptr = s_len; feed_lim = s_len;
    step(1'b0);
    check(out_valid == 1'b0, "R5 out_valid after flush", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R5 buffer empty after flush", 32'(in_ready), 32'd1);
    add_inst(1'b0, 6'h3E, 5'd0, 5'd31, 5'd0, 8'hFF);
    add_inst(1'b1, 6'h3F, 5'd0, 5'd0, 5'd31, 8'h1F);
    add_inst(1'b0, 6'h00, 5'd0, 5'd0, 5'd0, 8'h00);
    feed_lim = s_len; rpct = 100;
    repeat (30) step(1'b0);
    check(e_rd == e_wr, "R5 fresh stream decoded", 32'(e_rd), 32'(e_wr));

    // Random mix of lengths, window sizes and backpressure
    for (int i = 0; i < 300; i++) add_random();
    feed_lim = s_len; vpct = 70; rpct = 70;
    for (int c = 0; c < 6000 && e_rd < e_wr; c++) step(1'b0);
    check(e_rd == e_wr, "R4 random stream complete", 32'(e_rd), 32'(e_wr));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule